// File: doc/BRIEF.md
# Priority-Class Wormhole Mesh Router

This block is one node of a two-dimensional mesh that carries memory and cache traffic as multi-flit messages. It has five ports: the local tile and four neighbours. Each physical link carries four virtual channels. A channel's number is also its priority class, so requests travel on channel 0 and replies travel on channel 3. A message is 1 to 5 flits of 128 bits. The head flit carries the destination as mesh coordinates. The router sends the message first along Y until the row matches, then along X. The output channel it picks is reserved from the head flit until the tail flit has passed.

Every input channel has a two-slot buffer. The upstream sender keeps a credit count for each channel and spends one credit per flit it sends. When a flit leaves a buffer, the router returns a credit to the upstream sender one cycle later on a registered path. For each of its own output channels, the router keeps a credit counter for the downstream buffer. A credit that arrives from downstream is registered once before it is added to that counter. Each input can send one flit per cycle, and each output can accept one flit per cycle. When several flits compete for an output, the higher-numbered channel wins, and inputs on the same channel take turns.

Top module: `mesh_wormhole_router`

## Requirements
- R1: Ports are numbered 0 local, 1 toward larger Y, 2 toward larger X, 3 toward smaller Y, 4 toward smaller X. The head flit holds the destination X in bits [3:0] and the destination Y in bits [7:4]. A message whose Y differs from the router's row leaves on port 1 or 3. Otherwise, a message whose X differs leaves on port 2 or 4. Otherwise it leaves on port 0. Body flits follow the head flit.
- R2: A flit captured at clock edge E on an idle router appears on its output after edge E+1. Its channel number, head flag, tail flag and payload are unchanged.
- R3: Once a head flit without a tail flag has been forwarded on an output channel, that output channel carries only flits of the same message, in order, until the tail flit. A flit with both flags set reserves nothing.
- R4: Each output channel's credit counter starts at 2. No flit is sent on a channel whose counter is 0. A credit sampled from downstream at edge E allows a waiting flit to appear after edge E+2.
- R5: Every flit that leaves an input buffer returns one credit on that input port, tagged with the flit's channel number. The credit appears in the same cycle the flit appears at its output.
- R6: When flits on different channels contend for one output, the higher-numbered channel is forwarded first.
- R7: Inputs that keep requesting one output on the same channel are served in rotation.
- R8: Messages from one input on one channel leave in the order they arrived. No flit is lost or duplicated.
- R9: Each input channel buffers two flits independently. A channel that is blocked for lack of credits does not hold up another channel on the same input.
- R10: While reset is asserted, and in the first cycle after it is released, no output flit and no credit is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Flit present, one bit per input port |
| in_head | input | 5 | Head flag per input port |
| in_tail | input | 5 | Tail flag per input port |
| in_vc | input | 10 | Channel number, 2 bits per input port |
| in_flit | input | 640 | Flit payload, 128 bits per input port |
| cr_out_valid | output | 5 | Credit returned upstream, per input port |
| cr_out_vc | output | 10 | Channel of the returned credit, 2 bits per port |
| out_valid | output | 5 | Flit present, one bit per output port |
| out_head | output | 5 | Head flag per output port |
| out_tail | output | 5 | Tail flag per output port |
| out_vc | output | 10 | Channel number, 2 bits per output port |
| out_flit | output | 640 | Flit payload, 128 bits per output port |
| cr_in_valid | input | 5 | Credit arriving from downstream, per output port |
| cr_in_vc | input | 10 | Channel of the arriving credit, 2 bits per port |

## Verification
Two cases are hard to reach from the ports. The first is a message that stays open on an output channel while a second head flit, from another input on the same channel, competes for that output. The second is a channel that runs out of downstream credits while a sibling channel on the same input still has traffic. The bench produces the first case directly: it sends two three-flit messages on one channel from two inputs in the same cycles. It produces the second by withholding downstream credits for one output channel and then sending traffic on another channel of the same input. It then returns a single credit by hand to time when the stalled flit is released. A long random phase follows, with random message lengths, destinations, channels and credit return, and every flit is checked for message contiguity and per-source order.

// File: rtl/mesh_wormhole_router.sv
module mesh_wormhole_router #(
  parameter int FW    = 128,
  parameter int NVC   = 4,
  parameter int DEPTH = 2,
  parameter int XW    = 4,
  parameter int YW    = 4,
  parameter int MY_X  = 1,
  parameter int MY_Y  = 1,
  localparam int NP   = 5,
  localparam int VW   = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NP-1:0]      in_valid,
  input  logic [NP-1:0]      in_head,
  input  logic [NP-1:0]      in_tail,
  input  logic [NP*VW-1:0]   in_vc,
  input  logic [NP*FW-1:0]   in_flit,
  output logic [NP-1:0]      cr_out_valid,
  output logic [NP*VW-1:0]   cr_out_vc,
  output logic [NP-1:0]      out_valid,
  output logic [NP-1:0]      out_head,
  output logic [NP-1:0]      out_tail,
  output logic [NP*VW-1:0]   out_vc,
  output logic [NP*FW-1:0]   out_flit,
  input  logic [NP-1:0]      cr_in_valid,
  input  logic [NP*VW-1:0]   cr_in_vc
);

  typedef logic [2:0] port_t;

  logic [FW+1:0] frt  [NP][NVC];
  port_t         want [NP][NVC];
  logic          elig [NP][NVC];
  logic          own_v[NP][NVC];
  logic [CW-1:0] crd  [NP][NVC];
  logic [NP-1:0] cq_v;
  logic [VW-1:0] cq_vc[NP];
  port_t         rr   [NP];
  logic [NP-1:0] req, gnt, og;
  logic [VW-1:0] cvc  [NP];
  logic [VW-1:0] bvc  [NP];
  port_t         cout [NP];
  port_t         ow   [NP];

  function automatic port_t yx_route(input logic [XW-1:0] dx, input logic [YW-1:0] dy);
    if (dy > YW'(MY_Y)) return 3'd1;
    if (dy < YW'(MY_Y)) return 3'd3;
    if (dx > XW'(MY_X)) return 3'd2;
    if (dx < XW'(MY_X)) return 3'd4;
    return 3'd0;
  endfunction

  function automatic int rot(input port_t r, input int k);
    return (int'(r) + 1 + k) % NP;
  endfunction

  for (genvar gp = 0; gp < NP; gp++) begin : g_in
    for (genvar gv = 0; gv < NVC; gv++) begin : g_vc
      logic [FW+1:0] slot [DEPTH];
      logic [AW-1:0] rp, wp;
      logic [CW-1:0] cnt;
      port_t         rt_q;
      logic          push, pop;

      assign push = in_valid[gp] && (in_vc[gp*VW +: VW] == VW'(gv));
      assign pop  = gnt[gp] && (cvc[gp] == VW'(gv));
      assign frt[gp][gv]  = slot[rp];
      assign want[gp][gv] = frt[gp][gv][FW+1]
                          ? yx_route(frt[gp][gv][XW-1:0], frt[gp][gv][XW+YW-1:XW])
                          : rt_q;
      assign elig[gp][gv] = (cnt != '0) && (crd[want[gp][gv]][gv] != '0)
                          && !(frt[gp][gv][FW+1] && own_v[want[gp][gv]][gv]);

      always_ff @(posedge clk)
        if (push) slot[wp] <= {in_head[gp], in_tail[gp], in_flit[gp*FW +: FW]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rp   <= '0;
          wp   <= '0;
          cnt  <= '0;
          rt_q <= '0;
        end else begin
          if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (pop) begin
            rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (frt[gp][gv][FW+1]) rt_q <= want[gp][gv];
          end
          cnt <= cnt + CW'(push) - CW'(pop);
        end
      end

      p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt != CW'(DEPTH)));
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req[p]  = 1'b0;
      cvc[p]  = '0;
      cout[p] = '0;
      for (int v = 0; v < NVC; v++)
        if (elig[p][v]) begin
          req[p]  = 1'b1;
          cvc[p]  = VW'(v);
          cout[p] = want[p][v];
        end
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      og[o]  = 1'b0;
      ow[o]  = '0;
      bvc[o] = '0;
      for (int k = 0; k < NP; k++)
        if (req[rot(rr[o], k)] && cout[rot(rr[o], k)] == port_t'(o)
            && (!og[o] || cvc[rot(rr[o], k)] > bvc[o])) begin
          og[o]  = 1'b1;
          bvc[o] = cvc[rot(rr[o], k)];
          ow[o]  = port_t'(rot(rr[o], k));
        end
    end
  end

  always_comb
    for (int p = 0; p < NP; p++)
      gnt[p] = req[p] && og[cout[p]] && (ow[cout[p]] == port_t'(p));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= '0;
      out_head     <= '0;
      out_tail     <= '0;
      out_vc       <= '0;
      out_flit     <= '0;
      cr_out_valid <= '0;
      cr_out_vc    <= '0;
      cq_v         <= '0;
      for (int o = 0; o < NP; o++) begin
        rr[o]    <= '0;
        cq_vc[o] <= '0;
      end
    end else begin
      out_valid    <= og;
      cr_out_valid <= gnt;
      cq_v         <= cr_in_valid;
      for (int o = 0; o < NP; o++) begin
        cq_vc[o]               <= cr_in_vc[o*VW +: VW];
        cr_out_vc[o*VW +: VW]  <= cvc[o];
        if (og[o]) begin
          rr[o]                <= ow[o];
          out_vc[o*VW +: VW]   <= cvc[ow[o]];
          out_head[o]          <= frt[ow[o]][cvc[ow[o]]][FW+1];
          out_tail[o]          <= frt[ow[o]][cvc[ow[o]]][FW];
          out_flit[o*FW +: FW] <= frt[ow[o]][cvc[ow[o]]][FW-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NP; o++)
        for (int v = 0; v < NVC; v++) begin
          own_v[o][v] <= 1'b0;
          crd[o][v]   <= CW'(DEPTH);
        end
    end else begin
      for (int o = 0; o < NP; o++)
        for (int v = 0; v < NVC; v++) begin
          if (og[o] && cvc[ow[o]] == VW'(v)) begin
            if (frt[ow[o]][v][FW+1] && !frt[ow[o]][v][FW]) own_v[o][v] <= 1'b1;
            else if (frt[ow[o]][v][FW])                     own_v[o][v] <= 1'b0;
          end
          if ((og[o] && cvc[ow[o]] == VW'(v)) && !(cq_v[o] && cq_vc[o] == VW'(v)))
            crd[o][v] <= crd[o][v] - 1'b1;
          else if (!(og[o] && cvc[ow[o]] == VW'(v)) && (cq_v[o] && cq_vc[o] == VW'(v)))
            crd[o][v] <= crd[o][v] + 1'b1;
        end
    end
  end

  logic open_q [NP][NVC];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NP; o++)
        for (int v = 0; v < NVC; v++) open_q[o][v] <= 1'b0;
    end else begin
      for (int o = 0; o < NP; o++)
        if (out_valid[o]) begin
          if (out_tail[o])      open_q[o][out_vc[o*VW +: VW]] <= 1'b0;
          else if (out_head[o]) open_q[o][out_vc[o*VW +: VW]] <= 1'b1;
        end
    end
  end

  p_credit_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(cr_out_valid));

  for (genvar go = 0; go < NP; go++) begin : g_chk
    p_body_in_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && !out_head[go]) |-> open_q[go][out_vc[go*VW +: VW]]);
    p_head_on_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && out_head[go]) |-> !open_q[go][out_vc[go*VW +: VW]]);
    for (genvar gv = 0; gv < NVC; gv++) begin : g_cr
      p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        crd[go][gv] <= CW'(DEPTH));
    end
  end

  p_x_only_in_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid[2] && out_head[2]) || (out_valid[4] && out_head[4])) |->
    ((out_valid[2] && out_head[2]) ? out_flit[2*FW+XW +: YW] : out_flit[4*FW+XW +: YW]) == YW'(MY_Y));
  p_y_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[1] && out_head[1]) |-> (out_flit[1*FW+XW +: YW] > YW'(MY_Y)));
  p_y_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[3] && out_head[3]) |-> (out_flit[3*FW+XW +: YW] < YW'(MY_Y)));

endmodule

// File: tb/tb_mesh_wormhole_router.sv
module tb_mesh_wormhole_router;
  localparam int FW = 128;
  localparam int NP = 5;
  localparam int NV = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [NP-1:0] in_valid, in_head, in_tail, cr_out_valid, out_valid, out_head, out_tail, cr_in_valid;
  logic [NP*2-1:0] in_vc, cr_out_vc, out_vc, cr_in_vc;
  logic [NP*FW-1:0] in_flit, out_flit;

  mesh_wormhole_router dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail), .in_vc(in_vc), .in_flit(in_flit),
    .cr_out_valid(cr_out_valid), .cr_out_vc(cr_out_vc),
    .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail), .out_vc(out_vc), .out_flit(out_flit),
    .cr_in_valid(cr_in_valid), .cr_in_vc(cr_in_vc));

  int errs = 0, checks = 0, sent = 0, recvd = 0;
  int up_cr[NP][NV], pend[NP][NV], nid[NP][NV], rid[NP][NV];
  bit hold[NP][NV];
  bit act[NP][NV];
  int mlen[NP][NV], midx[NP][NV], mx[NP][NV], my[NP][NV];
  bit opn[NP][NV];
  int osrc[NP][NV], oid[NP][NV], onext[NP][NV];
  int lg_n;
  int lg_port[64], lg_src[64], lg_vc[64];
  logic [NP-1:0] cur_ov, cur_cr;
  logic [NP*2-1:0] cur_crvc;
  int force_o = -1, force_v = 0;
  bit no_new = 0, done = 0;

  task automatic chk(input bit ok, input string r, input int a, input int e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  function automatic int exp_port(input int x, input int y);
    if (y != 1) return (y > 1) ? 1 : 3;
    if (x != 1) return (x > 1) ? 2 : 4;
    return 0;
  endfunction

  task automatic send(input int p, input int v, input int x, input int y, input int id,
                      input int idx, input int len);
    logic [FW-1:0] f;
    f = {$urandom, $urandom, $urandom, $urandom};
    f[3:0] = 4'(x); f[7:4] = 4'(y); f[15:8] = 8'(id); f[18:16] = 3'(p);
    f[21:20] = 2'(v); f[26:24] = 3'(idx); f[29:27] = 3'(len);
    in_valid[p] = 1'b1;
    in_vc[p*2 +: 2] = 2'(v);
    in_head[p] = (idx == 0);
    in_tail[p] = (idx == len - 1);
    in_flit[p*FW +: FW] = f;
    up_cr[p][v]--;
    sent++;
  endtask

  task automatic push(input int p, input int v, input int x, input int y, input int len);
    if (!act[p][v]) begin
      act[p][v] = 1; mlen[p][v] = len; midx[p][v] = 0; mx[p][v] = x; my[p][v] = y;
    end
    send(p, v, mx[p][v], my[p][v], nid[p][v], midx[p][v], mlen[p][v]);
    midx[p][v]++;
    if (midx[p][v] == mlen[p][v]) begin
      act[p][v] = 0;
      nid[p][v] = (nid[p][v] + 1) % 256;
    end
  endtask

  task automatic monitor();
    cur_ov = out_valid; cur_cr = cr_out_valid; cur_crvc = cr_out_vc;
    for (int p = 0; p < NP; p++)
      if (cr_out_valid[p]) begin
        up_cr[p][cr_out_vc[p*2 +: 2]]++;
        chk(up_cr[p][cr_out_vc[p*2 +: 2]] <= 2, "R5 upstream credit bound", up_cr[p][cr_out_vc[p*2 +: 2]], 2);
      end
    if (out_valid != 0 || cr_out_valid != 0)
      chk($countones(out_valid) == $countones(cr_out_valid), "R5 credits per flit",
          $countones(cr_out_valid), $countones(out_valid));
    for (int o = 0; o < NP; o++)
      if (out_valid[o]) begin
        logic [FW-1:0] f;
        int x, y, id, s, fv, idx, len, v;
        f = out_flit[o*FW +: FW];
        x = int'(f[3:0]); y = int'(f[7:4]); id = int'(f[15:8]); s = int'(f[18:16]);
        fv = int'(f[21:20]); idx = int'(f[26:24]); len = int'(f[29:27]);
        v = int'(out_vc[o*2 +: 2]);
        chk(exp_port(x, y) == o, "R1 output port", o, exp_port(x, y));
        chk(v == fv, "R2 channel kept", v, fv);
        chk(out_head[o] == (idx == 0), "R2 head flag", int'(out_head[o]), int'(idx == 0));
        chk(out_tail[o] == (idx == len - 1), "R2 tail flag", int'(out_tail[o]), int'(idx == len - 1));
        if (opn[o][v])
          chk(s == osrc[o][v] && id == oid[o][v] && idx == onext[o][v], "R3 wormhole contiguity",
              s * 1000 + idx, osrc[o][v] * 1000 + onext[o][v]);
        else
          chk(idx == 0, "R3 new message starts with head", idx, 0);
        if (out_tail[o]) opn[o][v] = 0;
        else begin opn[o][v] = 1; osrc[o][v] = s; oid[o][v] = id; onext[o][v] = idx + 1; end
        if (idx == 0) begin
          chk(id == rid[s][v], "R8 per-source order", id, rid[s][v]);
          rid[s][v] = (id + 1) % 256;
        end
        pend[o][v]++;
        chk(pend[o][v] <= 2, "R4 downstream credit limit", pend[o][v], 2);
        recvd++;
        if (lg_n < 64) begin
          lg_port[lg_n] = o; lg_src[lg_n] = s; lg_vc[lg_n] = v; lg_n++;
        end
      end
  endtask

  task automatic ret_credits();
    for (int o = 0; o < NP; o++) begin
      if (o == force_o) begin
        cr_in_valid[o] = 1'b1; cr_in_vc[o*2 +: 2] = 2'(force_v); pend[o][force_v]--;
        force_o = -1;
      end else if ($urandom % 4 != 0) begin
        for (int v = NV - 1; v >= 0; v--)
          if (!cr_in_valid[o] && pend[o][v] > 0 && !hold[o][v]) begin
            cr_in_valid[o] = 1'b1; cr_in_vc[o*2 +: 2] = 2'(v); pend[o][v]--;
          end
      end
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    monitor();
    in_valid = '0; in_head = '0; in_tail = '0;
    cr_in_valid = '0;
    ret_credits();
  endtask

  task automatic gen();
    for (int p = 0; p < NP; p++)
      if ($urandom % 2 == 0) begin
        int v;
        v = int'($urandom % NV);
        if (up_cr[p][v] > 0 && (act[p][v] || !no_new))
          push(p, v, int'($urandom % 3), int'($urandom % 3), 1 + int'($urandom % 5));
      end
  endtask

  function automatic int count_log(input int port, input int vc);
    int c;
    c = 0;
    for (int i = 0; i < lg_n; i++) if (lg_port[i] == port && lg_vc[i] == vc) c++;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int p = 0; p < NP; p++)
      for (int v = 0; v < NV; v++) begin
        up_cr[p][v] = 2; pend[p][v] = 0; nid[p][v] = 0; rid[p][v] = 0; hold[p][v] = 0;
        act[p][v] = 0; opn[p][v] = 0;
      end
    rst_n = 1'b0;
    in_valid = '0; in_head = '0; in_tail = '0; in_vc = '0; in_flit = '0;
    cr_in_valid = '0; cr_in_vc = '0;
    lg_n = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && cr_out_valid == 0, "R10 idle in reset", int'(out_valid | cr_out_valid), 0);
    rst_n = 1'b1;
    cyc();
    chk(cur_ov == 0 && cur_cr == 0, "R10 idle after reset", int'(cur_ov | cur_cr), 0);

    // R2, R5: single flit from local to +X, latency and credit return
    push(0, 0, 2, 1, 1);
    cyc();
    chk(cur_ov == 0, "R2 not early", int'(cur_ov), 0);
    cyc();
    chk(cur_ov == 5'b00100, "R2 one-hop latency", int'(cur_ov), 4);
    chk(cur_cr == 5'b00001 && cur_crvc[1:0] == 2'd0, "R5 credit on input 0 vc0", int'(cur_cr), 1);
    repeat (4) cyc();

    // R4, R9: starve output 2 channel 2
    hold[2][2] = 1;
    lg_n = 0;
    for (int k = 0; k < 3; k++) begin
      while (up_cr[0][2] == 0) cyc();
      push(0, 2, 2, 1, 1);
      cyc();
    end
    repeat (6) cyc();
    chk(count_log(2, 2) == 2, "R4 stall at zero credit", count_log(2, 2), 2);
    lg_n = 0;
    push(0, 1, 2, 1, 1);
    repeat (4) cyc();
    chk(count_log(2, 1) == 1, "R9 other channel passes", count_log(2, 1), 1);
    repeat (4) cyc();
    lg_n = 0;
    force_o = 2; force_v = 2;
    cyc();
    cyc();
    cyc();
    chk(count_log(2, 2) == 0, "R4 not before credit pipeline", count_log(2, 2), 0);
    cyc();
    chk(count_log(2, 2) == 1, "R4 release after credit", count_log(2, 2), 1);
    hold[2][2] = 0;
    repeat (10) cyc();

    // R6: vc0 and vc3 contend for local port
    lg_n = 0;
    push(1, 0, 1, 1, 1);
    push(3, 3, 1, 1, 1);
    repeat (8) cyc();
    chk(lg_n == 2, "R6 two flits out", lg_n, 2);
    chk(lg_vc[0] == 3, "R6 higher channel first", lg_vc[0], 3);
    chk(lg_vc[1] == 0, "R6 lower channel second", lg_vc[1], 0);
    repeat (4) cyc();

    // R7: two inputs, same channel, same output
    lg_n = 0;
    push(2, 1, 1, 1, 1);
    push(4, 1, 1, 1, 1);
    cyc();
    push(2, 1, 1, 1, 1);
    push(4, 1, 1, 1, 1);
    repeat (12) cyc();
    chk(lg_n == 4, "R7 four flits out", lg_n, 4);
    for (int i = 1; i < 4; i++)
      chk(lg_src[i] != lg_src[i-1], "R7 rotation", lg_src[i], 6 - lg_src[i-1]);
    repeat (4) cyc();

    // R3: two 3-flit messages on one channel to one output
    lg_n = 0;
    begin
      int k1, k3;
      k1 = 0; k3 = 0;
      while (k1 < 3 || k3 < 3) begin
        if (k1 < 3 && up_cr[1][2] > 0) begin push(1, 2, 2, 1, 3); k1++; end
        if (k3 < 3 && up_cr[3][2] > 0) begin push(3, 2, 2, 1, 3); k3++; end
        cyc();
      end
    end
    repeat (16) cyc();
    chk(lg_n == 6, "R3 six flits out", lg_n, 6);
    chk(lg_src[0] == lg_src[1] && lg_src[1] == lg_src[2], "R3 first message whole", lg_src[1], lg_src[0]);
    chk(lg_src[3] == lg_src[4] && lg_src[4] == lg_src[5], "R3 second message whole", lg_src[4], lg_src[3]);

    // random phase
    repeat (4000) begin
      gen();
      cyc();
    end
    no_new = 1;
    repeat (400) begin
      gen();
      cyc();
    end
    repeat (100) cyc();
    chk(recvd == sent, "R8 no flit lost", recvd, sent);
    for (int p = 0; p < NP; p++)
      for (int v = 0; v < NV; v++)
        chk(up_cr[p][v] == 2 && !act[p][v], "R5 all credits back", up_cr[p][v], 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule